// File: doc/BRIEF.md
# Event timer register file

This block is the memory-mapped front end of a multi-channel event timer. It decodes 4-byte and 8-byte reads and writes inside a 1024-byte window. It holds the global registers: a computed capability word, a two-bit general configuration, an interrupt status word and a 64-bit main counter. It also holds the per-channel configuration, comparator and message-route words that the comparator logic reads.

The general configuration drives two levels towards the channels: a run enable and a legacy-replacement flag. Each channel returns a one-cycle match strobe. A match sets that channel's status bit when the channel is configured for level-type interrupts. Software clears a status bit by writing a one to it, and the block then sends a one-cycle clear strobe back to that channel so that the channel can drop its level interrupt.

The main counter advances once per clock while the block is enabled and holds its value while halted. Software may load it in either state. Read data returns one cycle after the request, together with a valid strobe.

Top module: `tmr_regblk`

## Requirements
- R1: Global registers sit at offsets 0x00 (capability), 0x10 (configuration), 0x20 (status) and 0xF0 (main counter). Channel n uses 0x100 + n*0x20, and address bits [4:3] pick configuration (0), comparator (1) or route (2). Any other offset, slot 3 of a channel, or a channel index at or above the channel count reads as zero, and a write there changes nothing. Read data and a one-cycle valid come out in the cycle after the request.
- R2: Address bit 2 selects the upper 32-bit half of a register. A 4-byte write changes only the selected half, from write-data bits 31:0. A read returns the selected half in bits 31:0 with zero above it, except that an 8-byte read at bit 2 = 0 returns all 64 bits.
- R3: The capability word is read-only. It holds revision 1 in bits 7:0, the channel count minus one in bits 12:8, a one in bit 13 (64-bit counter), a one in bit 15 (legacy route capable), the VENDOR_ID parameter in bits 31:16 and the TICK_FS parameter in bits 63:32 (default 10,000,000).
- R4: Only configuration bits 1:0 are writable and all other bits read as zero. Bit 0 drives run_en and bit 1 drives legacy_en.
- R5: The main counter adds one per clock while run_en is high and holds while it is low. A write loads it in either state, and the write takes priority over the increment in that cycle.
- R6: A match strobe sets a channel's status bit (status bit n for channel n) only when bit 1 of that channel's configuration (level type) is one. An edge-type channel's match leaves status unchanged.
- R7: Writing a one to a status bit at offset 0x20 clears it, and writing a zero has no effect. In the cycle after the write, ch_stat_clr pulses for each bit that was both written as one and set.
- R8: When a match and a clear for the same level-type channel fall in one cycle, the status bit ends up set.
- R9: The writable bits of a channel configuration are given by mask 0x7F4E. Bits 4 and 5 always read as one, and bits 63:32 read as the ROUTE_CAP parameter. Comparators reset to all ones and route words reset to zero.
- R10: After reset the configuration, status and counter read zero, and run_en, legacy_en and ch_stat_clr are low.
- R11: The channel count is NUM_TIMERS clamped to the range 3 to 32. For example, NUM_TIMERS = 40 reports 31 in capability bits 12:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_addr | input | 10 | Byte offset in the window |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| run_en | output | 1 | Overall enable level to the channels |
| legacy_en | output | 1 | Legacy replacement level to the channels |
| ch_match | input | NT | Per-channel match strobes |
| ch_stat_clr | output | NT | Per-channel status-clear strobes |
| ch_cfg | output | NT*64 | Channel configuration words, channel n at bits n*64 and up |
| ch_cmp | output | NT*64 | Channel comparator words |
| ch_route | output | NT*64 | Channel route words |

## Verification
Two functions can land in the same cycle. The first pair is a status-bit set from a match strobe and a software clear of that same bit. The bench drives ch_match in the very cycle that a write-one-to-clear to offset 0x20 is presented. It expects the later status read to show the bit still set, and it expects the clear strobe to pulse because the bit was set when the write arrived. The second pair is a counter write and the per-clock increment while running. The bench records the edge at which the load is sampled. It then predicts a later read exactly as the loaded value plus the number of increment edges between the load and the read, and it repeats this prediction across a halt and a resume.

// File: rtl/tmr_regblk_pkg.sv
package tmr_regblk_pkg;

  localparam int unsigned TMR_MIN = 3;
  localparam int unsigned TMR_MAX = 32;
  localparam int unsigned DW      = 64;
  localparam int unsigned HW      = DW / 2;

  // writable bits of a channel configuration word
  localparam logic [DW-1:0] TCFG_WMASK = 64'h0000_0000_0000_7F4E;
  // read-only ones of a channel configuration word
  localparam logic [DW-1:0] TCFG_FIXED = 64'h0000_0000_0000_0030;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAP,
    SEL_GCFG,
    SEL_STAT,
    SEL_CNT,
    SEL_TCFG,
    SEL_TCMP,
    SEL_TRTE
  } reg_sel_e;

  function automatic int unsigned clamp_timers(input int unsigned n);
    if (n < TMR_MIN) return TMR_MIN;
    if (n > TMR_MAX) return TMR_MAX;
    return n;
  endfunction

  function automatic logic [DW-1:0] cap_word(input int unsigned nt,
                                             input logic [15:0] vid,
                                             input logic [31:0] fs);
    logic [4:0] lastn;
    lastn = 5'(nt - 1);
    return {fs, vid, 1'b1, 1'b0, 1'b1, lastn, 8'h01};
  endfunction

  // merge a write into the old value according to half select and width
  function automatic logic [DW-1:0] half_merge(input logic [DW-1:0] old,
                                               input logic [DW-1:0] wd,
                                               input logic upper,
                                               input logic wide);
    if (upper)     return {wd[HW-1:0], old[HW-1:0]};
    else if (wide) return wd;
    else           return {old[DW-1:HW], wd[HW-1:0]};
  endfunction

  // align the selected half of a register onto the read bus
  function automatic logic [DW-1:0] half_read(input logic [DW-1:0] v,
                                              input logic upper,
                                              input logic wide);
    if (upper)     return {{HW{1'b0}}, v[DW-1:HW]};
    else if (wide) return v;
    else           return {{HW{1'b0}}, v[HW-1:0]};
  endfunction

  function automatic logic [DW-1:0] mask_merge(input logic [DW-1:0] nv,
                                               input logic [DW-1:0] old,
                                               input logic [DW-1:0] mask);
    return (nv & mask) | (old & ~mask);
  endfunction

endpackage

// File: rtl/tmr_regblk_decode.sv
module tmr_regblk_decode
  import tmr_regblk_pkg::*;
#(
  parameter int unsigned NT   = 3,
  parameter int unsigned IDXW = 2
)(
  input  logic [9:2]      addr,
  output reg_sel_e        sel,
  output logic [IDXW-1:0] tidx,
  output logic            upper
);

  logic [4:0] slot;

  always_comb begin
    upper = addr[2];
    sel   = SEL_NONE;
    slot  = 5'd0;
    if (addr[9:8] == 2'b00) begin
      case (addr[7:3])
        5'h00:   sel = SEL_CAP;
        5'h02:   sel = SEL_GCFG;
        5'h04:   sel = SEL_STAT;
        5'h1E:   sel = SEL_CNT;
        default: sel = SEL_NONE;
      endcase
    end else begin
      slot = addr[9:5] - 5'd8;
      if (32'(slot) < NT) begin
        case (addr[4:3])
          2'd0:    sel = SEL_TCFG;
          2'd1:    sel = SEL_TCMP;
          2'd2:    sel = SEL_TRTE;
          default: sel = SEL_NONE;
        endcase
      end
    end
  end

  assign tidx = slot[IDXW-1:0];

endmodule

// File: rtl/tmr_regblk_counter.sv
module tmr_regblk_counter
  import tmr_regblk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wr,
  input  logic          upper,
  input  logic          wide,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt_q,
  output logic          cnt_inc
);

  // a load wins over the increment in the same cycle
  assign cnt_inc = run && !wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr)      cnt_q <= half_merge(cnt_q, wdata, upper, wide);
    else if (cnt_inc) cnt_q <= cnt_q + 64'd1;
  end

endmodule

// File: rtl/tmr_regblk_status.sv
module tmr_regblk_status #(
  parameter int unsigned NT = 3
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] set_mask,
  input  logic          w1c_en,
  input  logic [NT-1:0] w1c_bits,
  output logic [NT-1:0] stat_q,
  output logic [NT-1:0] clr_q
);

  logic [NT-1:0] clr_now;

  assign clr_now = w1c_en ? (w1c_bits & stat_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      clr_q  <= '0;
    end else begin
      // a new match outranks a clear arriving in the same cycle
      stat_q <= (stat_q & ~clr_now) | set_mask;
      clr_q  <= clr_now;
    end
  end

endmodule

// File: rtl/tmr_regblk_chan.sv
module tmr_regblk_chan
  import tmr_regblk_pkg::*;
#(
  parameter int unsigned NT        = 3,
  parameter int unsigned IDXW      = 2,
  parameter logic [31:0] ROUTE_CAP = 32'h0000_0F00
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cfg,
  input  logic             wr_cmp,
  input  logic             wr_rte,
  input  logic [IDXW-1:0]  tidx,
  input  logic             upper,
  input  logic             wide,
  input  logic [DW-1:0]    wdata,
  output logic [NT*DW-1:0] cfg_flat,
  output logic [NT*DW-1:0] cmp_flat,
  output logic [NT*DW-1:0] rte_flat
);

  localparam logic [DW-1:0] CFG_RST = {ROUTE_CAP, 32'h0} | TCFG_FIXED;

  for (genvar i = 0; i < int'(NT); i++) begin : g_tmr
    logic [DW-1:0] cfg_q;
    logic [DW-1:0] cmp_q;
    logic [DW-1:0] rte_q;
    logic          hit;

    assign hit = (tidx == IDXW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= CFG_RST;
        cmp_q <= '1;
        rte_q <= '0;
      end else begin
        if (wr_cfg && hit)
          cfg_q <= mask_merge(half_merge(cfg_q, wdata, upper, wide), cfg_q, TCFG_WMASK);
        if (wr_cmp && hit)
          cmp_q <= half_merge(cmp_q, wdata, upper, wide);
        if (wr_rte && hit)
          rte_q <= half_merge(rte_q, wdata, upper, wide);
      end
    end

    assign cfg_flat[i*DW +: DW] = cfg_q;
    assign cmp_flat[i*DW +: DW] = cmp_q;
    assign rte_flat[i*DW +: DW] = rte_q;
  end

endmodule

// File: rtl/tmr_regblk.sv
module tmr_regblk
  import tmr_regblk_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 3,
  parameter logic [15:0] VENDOR_ID  = 16'h1AB5,
  parameter logic [31:0] TICK_FS    = 32'd10_000_000,
  parameter logic [31:0] ROUTE_CAP  = 32'h0000_0F00,
  localparam int unsigned NT        = clamp_timers(NUM_TIMERS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_wr,
  input  logic             bus_wide,
  input  logic [9:0]       bus_addr,
  input  logic [63:0]      bus_wdata,
  output logic [63:0]      bus_rdata,
  output logic             bus_rvalid,
  output logic             run_en,
  output logic             legacy_en,
  input  logic [NT-1:0]    ch_match,
  output logic [NT-1:0]    ch_stat_clr,
  output logic [NT*64-1:0] ch_cfg,
  output logic [NT*64-1:0] ch_cmp,
  output logic [NT*64-1:0] ch_route
);

  localparam int unsigned IDXW = (NT > 1) ? $clog2(NT) : 1;
  localparam logic [DW-1:0] CAP = cap_word(NT, VENDOR_ID, TICK_FS);

  reg_sel_e        sel;
  logic [IDXW-1:0] tidx;
  logic            upper;
  logic            dec_hit;
  logic            acc_wr, acc_rd;
  logic            gcfg_wr, cnt_wr, stat_w1c;
  logic            tcfg_wr, tcmp_wr, trte_wr;
  logic [1:0]      gcfg_q;
  logic [DW-1:0]   gcfg_merged;
  logic [DW-1:0]   cnt_q;
  logic            cnt_inc;
  logic [NT-1:0]   stat_q;
  logic [NT-1:0]   set_mask;
  logic [DW-1:0]   rd_val;
  logic            unused_addr_lo;

  assign unused_addr_lo = ^bus_addr[1:0];

  tmr_regblk_decode #(.NT(NT), .IDXW(IDXW)) u_decode (
    .addr  (bus_addr[9:2]),
    .sel   (sel),
    .tidx  (tidx),
    .upper (upper)
  );

  assign dec_hit  = (sel != SEL_NONE);
  assign acc_wr   = bus_req && bus_wr;
  assign acc_rd   = bus_req && !bus_wr;
  assign gcfg_wr  = acc_wr && (sel == SEL_GCFG);
  assign cnt_wr   = acc_wr && (sel == SEL_CNT);
  assign stat_w1c = acc_wr && (sel == SEL_STAT) && !upper;
  assign tcfg_wr  = acc_wr && (sel == SEL_TCFG);
  assign tcmp_wr  = acc_wr && (sel == SEL_TCMP);
  assign trte_wr  = acc_wr && (sel == SEL_TRTE);

  // general configuration: only the two low bits are kept
  assign gcfg_merged = half_merge({62'd0, gcfg_q}, bus_wdata, upper, bus_wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gcfg_q <= 2'b00;
    else if (gcfg_wr) gcfg_q <= gcfg_merged[1:0];
  end

  assign run_en    = gcfg_q[0];
  assign legacy_en = gcfg_q[1];

  tmr_regblk_counter u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_en),
    .wr      (cnt_wr),
    .upper   (upper),
    .wide    (bus_wide),
    .wdata   (bus_wdata),
    .cnt_q   (cnt_q),
    .cnt_inc (cnt_inc)
  );

  // a match counts only for channels set to level type
  always_comb begin
    for (int i = 0; i < int'(NT); i++)
      set_mask[i] = ch_match[i] && ch_cfg[i*DW + 1];
  end

  tmr_regblk_status #(.NT(NT)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_mask),
    .w1c_en   (stat_w1c),
    .w1c_bits (bus_wdata[NT-1:0]),
    .stat_q   (stat_q),
    .clr_q    (ch_stat_clr)
  );

  tmr_regblk_chan #(.NT(NT), .IDXW(IDXW), .ROUTE_CAP(ROUTE_CAP)) u_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cfg   (tcfg_wr),
    .wr_cmp   (tcmp_wr),
    .wr_rte   (trte_wr),
    .tidx     (tidx),
    .upper    (upper),
    .wide     (bus_wide),
    .wdata    (bus_wdata),
    .cfg_flat (ch_cfg),
    .cmp_flat (ch_cmp),
    .rte_flat (ch_route)
  );

  always_comb begin
    case (sel)
      SEL_CAP:  rd_val = CAP;
      SEL_GCFG: rd_val = {62'd0, gcfg_q};
      SEL_STAT: rd_val = {{(DW-NT){1'b0}}, stat_q};
      SEL_CNT:  rd_val = cnt_q;
      SEL_TCFG: rd_val = ch_cfg[tidx*DW +: DW];
      SEL_TCMP: rd_val = ch_cmp[tidx*DW +: DW];
      SEL_TRTE: rd_val = ch_route[tidx*DW +: DW];
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= acc_rd;
      if (acc_rd) bus_rdata <= half_read(rd_val, upper, bus_wide);
    end
  end

endmodule

// File: rtl/tmr_regblk_chk.sv
module tmr_regblk_chk #(
  parameter int unsigned NT = 3
)(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_wr,
  input logic          dec_hit,
  input logic [63:0]   bus_rdata,
  input logic          bus_rvalid,
  input logic          run_en,
  input logic          cnt_wr,
  input logic [63:0]   cnt_q,
  input logic [NT-1:0] stat_q,
  input logic [NT-1:0] set_mask,
  input logic          stat_w1c,
  input logic [NT-1:0] ch_stat_clr
);

  AST_READ_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr) |=> bus_rvalid);  // R1

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && !dec_hit) |=> (bus_rdata == 64'd0));  // R1

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr) |=> $stable(cnt_q));  // R5

  AST_RUN_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 64'd1));  // R5

  AST_CLEAR_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_stat_clr) |-> ((ch_stat_clr & ~$past(stat_q)) == '0));  // R7

  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_mask == '0) && !stat_w1c) |=> $stable(stat_q));  // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((stat_q & $past(set_mask)) == $past(set_mask)));  // R8

endmodule

bind tmr_regblk tmr_regblk_chk #(.NT(NT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_wr      (bus_wr),
  .dec_hit     (dec_hit),
  .bus_rdata   (bus_rdata),
  .bus_rvalid  (bus_rvalid),
  .run_en      (run_en),
  .cnt_wr      (cnt_wr),
  .cnt_q       (cnt_q),
  .stat_q      (stat_q),
  .set_mask    (set_mask),
  .stat_w1c    (stat_w1c),
  .ch_stat_clr (ch_stat_clr)
);

// File: tb/tmr_regblk_bench.sv
module tmr_regblk_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int          NT   = 3;
  localparam int          NTB  = 32;
  localparam logic [63:0] CAPX = (64'd10_000_000 << 32) | (64'h1AB5 << 16) |
                                 (64'd1 << 15) | (64'd1 << 13) |
                                 (64'(NT - 1) << 8) | 64'd1;
  localparam logic [63:0] TCFG_ONES = (64'h0000_0F00 << 32) | 64'h7F7E;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_wide = 1'b0;
  logic [9:0]    bus_addr = '0;
  logic [63:0]   bus_wdata = '0;
  logic [63:0]   bus_rdata;
  logic          bus_rvalid;
  logic          run_en, legacy_en;
  logic [NT-1:0] ch_match = '0;
  logic [NT-1:0] ch_stat_clr;
  logic [NT*64-1:0] ch_cfg, ch_cmp, ch_route;

  logic [63:0]     big_rdata;
  logic            big_rvalid, big_run, big_leg;
  logic [NTB-1:0]  big_clr;
  logic [NTB*64-1:0] big_cfg, big_cmp, big_rte;

  int          cyc = 0;
  int          n_chk = 0;
  int          n_err = 0;
  int          last_edge = 0;
  logic [63:0] last_rd = '0;
  logic [63:0] last_big = '0;
  logic [NT-1:0] clr_snap = '0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_regblk #(.NUM_TIMERS(NT)) u_tmr_regblk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .run_en(run_en),
    .legacy_en(legacy_en), .ch_match(ch_match), .ch_stat_clr(ch_stat_clr),
    .ch_cfg(ch_cfg), .ch_cmp(ch_cmp), .ch_route(ch_route)
  );

  tmr_regblk #(.NUM_TIMERS(40)) u_big (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(big_rdata), .bus_rvalid(big_rvalid), .run_en(big_run),
    .legacy_en(big_leg), .ch_match('0), .ch_stat_clr(big_clr),
    .ch_cfg(big_cfg), .ch_cmp(big_cmp), .ch_route(big_rte)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expectation per returned read
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      last_rd  = bus_rdata;
      last_big = big_rdata;
      if (exp_q.size() == 0) check("R1 unexpected read data", bus_rdata, 64'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [9:0] a, input logic w, input logic [63:0] d,
                    input logic [NT-1:0] m = '0);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_wide = w; bus_addr = a; bus_wdata = d;
    ch_match = m;
    last_edge = cyc + 1;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; ch_match = '0;
    clr_snap = ch_stat_clr;
  endtask

  // rel >= 0: expected value grows with the edges since edge rel
  task automatic rd(input logic [9:0] a, input logic w, input logic [63:0] e,
                    input string tag, input int rel = -1);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_wide = w; bus_addr = a;
    if (rel >= 0) e = e + 64'(cyc - rel);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [NT-1:0] m);
    @(negedge clk);
    ch_match = m;
    @(negedge clk);
    ch_match = '0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [63:0] x, v;
    int a, d, e;
    logic [NT*64-1:0] cfg_snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check("R10 run_en/legacy_en after reset", {62'd0, run_en, legacy_en}, 64'd0);
    check("R10 clear strobes after reset", {61'd0, ch_stat_clr}, 64'd0);
    rd(10'h010, 1'b1, 64'd0, "R10 configuration after reset");
    rd(10'h020, 1'b1, 64'd0, "R10 status after reset");
    rd(10'h0F0, 1'b1, 64'd0, "R10 counter after reset");

    // R3 capability, halves, read-only
    rd(10'h000, 1'b1, CAPX, "R3 capability wide");
    rd(10'h004, 1'b0, {32'd0, CAPX[63:32]}, "R3 R2 capability upper half");
    rd(10'h000, 1'b0, {32'd0, CAPX[31:0]}, "R3 R2 capability lower half");
    wr(10'h000, 1'b1, 64'd0);
    rd(10'h000, 1'b1, CAPX, "R3 capability after write");
    check("R11 clamped channel count", (last_big >> 8) & 64'h1F, 64'd31);

    // R4 configuration mask and output levels
    wr(10'h010, 1'b1, '1);
    rd(10'h010, 1'b1, 64'd3, "R4 configuration mask");
    check("R4 run_en/legacy_en set", {62'd0, run_en, legacy_en}, 64'd3);
    wr(10'h010, 1'b1, 64'd0);
    check("R4 run_en/legacy_en cleared", {62'd0, run_en, legacy_en}, 64'd0);

    // R5 R2 counter while halted
    wr(10'h0F0, 1'b1, 64'h1234_5678_9ABC_DEF0);
    rd(10'h0F0, 1'b1, 64'h1234_5678_9ABC_DEF0, "R5 halted load");
    wr(10'h0F4, 1'b0, 64'hFFFF_FFFF_CAFE_BABE);
    rd(10'h0F0, 1'b1, 64'hCAFE_BABE_9ABC_DEF0, "R2 narrow upper write");
    rd(10'h0F4, 1'b0, 64'h0000_0000_CAFE_BABE, "R2 narrow upper read");
    repeat (5) @(negedge clk);
    rd(10'h0F0, 1'b0, 64'h0000_0000_9ABC_DEF0, "R5 halted hold");

    // R5 running, load while running, halt, resume
    x = 64'h0000_0000_0000_0100;
    wr(10'h010, 1'b0, 64'd1);
    wr(10'h0F0, 1'b1, x);
    a = last_edge;
    repeat (7) @(negedge clk);
    rd(10'h0F0, 1'b1, x, "R5 live count after load", a);
    wr(10'h010, 1'b0, 64'd0);
    d = last_edge;
    v = x + 64'(d - a);
    rd(10'h0F0, 1'b1, v, "R5 value at halt");
    repeat (6) @(negedge clk);
    rd(10'h0F0, 1'b1, v, "R5 held after halt");
    wr(10'h010, 1'b0, 64'd1);
    e = last_edge;
    repeat (4) @(negedge clk);
    rd(10'h0F0, 1'b1, v, "R5 resumed count", e);
    wr(10'h010, 1'b0, 64'd0);

    // R6 R7 R8 status
    wr(10'h100, 1'b0, 64'd2);
    pulse(3'b001);
    rd(10'h020, 1'b1, 64'd1, "R6 level match sets status");
    pulse(3'b100);
    rd(10'h020, 1'b1, 64'd1, "R6 edge match leaves status");
    wr(10'h020, 1'b0, 64'd0);
    check("R7 zero write gives no strobe", {61'd0, clr_snap}, 64'd0);
    rd(10'h020, 1'b1, 64'd1, "R7 zero write keeps status");
    wr(10'h020, 1'b0, 64'd4);
    check("R7 strobe only for set bits", {61'd0, clr_snap}, 64'd0);
    wr(10'h020, 1'b0, 64'd1);
    check("R7 clear strobe", {61'd0, clr_snap}, 64'd1);
    rd(10'h020, 1'b1, 64'd0, "R7 status cleared");
    pulse(3'b001);
    wr(10'h020, 1'b0, 64'd1, 3'b001);
    check("R8 strobe with same-cycle match", {61'd0, clr_snap}, 64'd1);
    rd(10'h020, 1'b1, 64'd1, "R8 match outranks clear");
    wr(10'h020, 1'b0, 64'd1);

    // R9 channel words
    wr(10'h120, 1'b1, '1);
    rd(10'h120, 1'b1, TCFG_ONES, "R9 channel config mask");
    check("R9 channel config port", ch_cfg[127:64], TCFG_ONES);
    rd(10'h128, 1'b1, '1, "R9 comparator reset");
    wr(10'h12C, 1'b0, 64'h0000_0000_1111_2222);
    rd(10'h128, 1'b1, 64'h1111_2222_FFFF_FFFF, "R9 R2 comparator upper half");
    check("R9 comparator port", ch_cmp[127:64], 64'h1111_2222_FFFF_FFFF);
    rd(10'h150, 1'b1, 64'd0, "R9 route reset");
    wr(10'h150, 1'b1, 64'hDEAD_BEEF_0123_4567);
    rd(10'h150, 1'b1, 64'hDEAD_BEEF_0123_4567, "R9 route write");

    // R1 unmapped and out-of-range offsets
    cfg_snap = ch_cfg;
    wr(10'h160, 1'b1, '1);
    check("R1 write beyond channel count ignored", 64'(cfg_snap == ch_cfg), 64'd1);
    rd(10'h160, 1'b1, 64'd0, "R1 channel beyond count reads zero");
    rd(10'h118, 1'b1, 64'd0, "R1 slot 3 reads zero");
    rd(10'h3E0, 1'b1, 64'd0, "R1 top channel slot reads zero");
    wr(10'h008, 1'b1, '1);
    rd(10'h030, 1'b1, 64'd0, "R1 unmapped global reads zero");
    rd(10'h010, 1'b1, 64'd0, "R1 unmapped write leaves configuration");
    check("R1 unmapped write leaves levels", {62'd0, run_en, legacy_en}, 64'd0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R1 reads outstanding", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule